// File: doc/BRIEF.md
# Stretched-Clock Scan Sequencer with Result Buffer

This block runs the conversion side of a two-wire read transaction in which the converter paces itself from its own clock. When the serial front end reports that a valid read-addressed byte has finished (the ninth falling clock edge of the address byte), the sequencer starts to hold the serial clock low. While it holds the clock, it walks a list of analog channels. The list comes from a scan code, a top-channel field and a flag that claims the highest channel as a reference pin. For each channel the sequencer tracks for a fixed number of cycles, then asks a converter model for a sample over a request/ready handshake, and writes the 8-bit result into the next slot of a small result buffer.

After the last result is stored, the clock is let go and the buffer is served to the master one byte at a time, in conversion order. Each master acknowledge moves a read pointer on, and the pointer wraps to the first result after the last one. A not-acknowledge makes the slave let go of the data line until the bus reports a stop or a repeated start. Reading again only replays the stored results. Fresh results need a fresh read-addressed transaction.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, scl_hold, conv_req, rd_valid and sda_rel are all 0.
- R2: The cycle after an addr_rd_evt pulse, scl_hold is 1. conv_req stays 0 for exactly two cycles of tracking and rises in the third cycle. Every channel gets the same two tracking cycles before its request.
- R3: scl_hold stays 1 from the address event until the cycle after the last conversion is accepted (conv_req and conv_ready both 1). It is 0 from then on, and rd_valid becomes 1 at the same time.
- R4: Scan code 2'b00 converts channels 0 up to the top-channel field, in ascending order. Result k (k counted from 0) goes to buffer slot k.
- R5: Scan codes 2'b01, 2'b10 and 2'b11 convert only the channel named by the top-channel field.
- R6: A top-channel value above NCH-1 is treated as NCH-1.
- R7: With cfg_ref_pin = 1 under scan code 2'b00, channel NCH-1 is left out of the scan. A single-channel scan of that channel still converts it.
- R8: While rd_valid is 1, rd_byte shows result 0 first. Each rd_ack pulse moves to the next result, and after the last result the next rd_ack returns to result 0.
- R9: An rd_nack pulse while rd_valid is 1 sets sda_rel. While sda_rel is 1, rd_ack does not move the read position. A bus_end pulse clears sda_rel.
- R10: While results are being served, no conversion is requested until the next addr_rd_evt. A new address event starts a new scan, and reading then begins again at its result 0.
- R11: While scl_hold is 1, no single channel keeps the clock stretched for STRETCH_CYC cycles or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_rd_evt | input | 1 | One-cycle pulse: read-addressed byte complete, start a scan |
| cfg_scan | input | 2 | Scan code (2'b00 ascending up to top channel, others single channel) |
| cfg_sel | input | 4 | Top-channel / selected-channel field |
| cfg_ref_pin | input | 1 | 1 = highest channel is used as a reference pin |
| conv_req | output | 1 | Conversion request to the converter model |
| conv_ch | output | 4 | Channel to convert while conv_req is 1 |
| conv_ready | input | 1 | Converter accepts the request, conv_data is valid |
| conv_data | input | 8 | Conversion result |
| scl_hold | output | 1 | 1 = hold serial clock low (stretch) |
| rd_valid | output | 1 | Results are being served |
| rd_byte | output | 8 | Result byte at the read position |
| rd_ack | input | 1 | Pulse: master acknowledged the byte |
| rd_nack | input | 1 | Pulse: master did not acknowledge |
| bus_end | input | 1 | Pulse: stop or repeated start seen |
| sda_rel | output | 1 | 1 = data line released after a not-acknowledge |

## Verification
The scan is swept over every scan code, every top-channel value including the four out-of-range values, and both settings of the reference flag. The channel order is checked against an order computed in the bench, which separates the ascending mode from the single-channel mode and exposes the clamp and the reference skip. The converter answers with a latency that changes from request to request, so the stored data and its buffer slot are tied to the order of acceptance, not to fixed timing. Each scan is read back past its end to expose wrap errors. Some scans add a not-acknowledge with an acknowledge that must be ignored, and an idle stretch in which no rescan may start.

// File: rtl/adcscan_pkg.sv
package adcscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2,
    ST_SERVE = 2'd3
  } seq_st_e;

  localparam logic [1:0] SCAN_UPTO = 2'b00;

  // ascending multi-channel scan only for the "up to" code
  function automatic logic is_multi(input logic [1:0] code);
    return code == SCAN_UPTO;
  endfunction

endpackage

// File: rtl/scan_chan_step.sv
module scan_chan_step #(
  parameter int NCH = 12,
  parameter int CW  = 4
) (
  input  logic [CW-1:0] cur,
  input  logic [CW-1:0] sel,
  input  logic          multi,
  input  logic          skip_ref,
  output logic [CW-1:0] nxt,
  output logic          last
);
  localparam int REF_CH = NCH - 1;

  logic [CW:0] cand;

  always_comb begin
    cand = {1'b0, cur} + (CW+1)'(1);
    if (multi && skip_ref && cand == (CW+1)'(REF_CH))
      cand = cand + (CW+1)'(1);
    last = !multi || (cand > {1'b0, sel});
    nxt  = cand[CW-1:0];
  end
endmodule

// File: rtl/scan_result_buf.sv
module scan_result_buf #(
  parameter int DEPTH = 12,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adcscan_pkg::*;
#(
  parameter int NCH         = 12,
  parameter int DW          = 8,
  parameter int TRK_CYC     = 2,
  parameter int STRETCH_CYC = 380
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_rd_evt,
  input  logic [1:0]             cfg_scan,
  input  logic [$clog2(NCH)-1:0] cfg_sel,
  input  logic                   cfg_ref_pin,
  output logic                   conv_req,
  output logic [$clog2(NCH)-1:0] conv_ch,
  input  logic                   conv_ready,
  input  logic [DW-1:0]          conv_data,
  output logic                   scl_hold,
  output logic                   rd_valid,
  output logic [DW-1:0]          rd_byte,
  input  logic                   rd_ack,
  input  logic                   rd_nack,
  input  logic                   bus_end,
  output logic                   sda_rel
);
  localparam int CW     = $clog2(NCH);
  localparam int DEPTH  = (NCH > 8) ? 12 : 8;
  localparam int AW     = $clog2(DEPTH);
  localparam int CNTW   = $clog2(DEPTH + 1);
  localparam int TW     = $clog2(TRK_CYC + 1);
  localparam int SW     = $clog2(STRETCH_CYC + 1);
  localparam int REF_CH = NCH - 1;

  seq_st_e         st;
  logic [TW-1:0]   trk_cnt;
  logic [CW-1:0]   cur_ch, sel_q, sel_c, first_ch, step_nxt;
  logic            multi_q, skip_q, step_last;
  logic [AW-1:0]   wr_idx, rd_ptr;
  logic [CNTW-1:0] n_res;
  logic [SW-1:0]   str_cnt;

  // named internal events
  logic tracking, conv_done, pop_ok, ptr_last;
  assign tracking  = (st == ST_TRACK);
  assign conv_done = (st == ST_CONV) && conv_ready;
  assign pop_ok    = rd_ack && (st == ST_SERVE) && !sda_rel;
  assign ptr_last  = (CNTW'(rd_ptr) + CNTW'(1)) == n_res;

  generate
    if ((1 << CW) == NCH) begin : g_noclamp
      assign sel_c = cfg_sel;
    end else begin : g_clamp
      assign sel_c = (cfg_sel > CW'(REF_CH)) ? CW'(REF_CH) : cfg_sel;
    end
  endgenerate

  assign first_ch = is_multi(cfg_scan) ? '0 : sel_c;

  scan_chan_step #(.NCH(NCH), .CW(CW)) step_i (
    .cur(cur_ch), .sel(sel_q), .multi(multi_q), .skip_ref(skip_q),
    .nxt(step_nxt), .last(step_last)
  );

  scan_result_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) buf_i (
    .clk(clk), .we(conv_done), .waddr(wr_idx), .wdata(conv_data),
    .raddr(rd_ptr), .rdata(rd_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      trk_cnt <= '0;
      cur_ch  <= '0;
      sel_q   <= '0;
      multi_q <= 1'b0;
      skip_q  <= 1'b0;
      wr_idx  <= '0;
      rd_ptr  <= '0;
      n_res   <= '0;
      sda_rel <= 1'b0;
    end else if (addr_rd_evt) begin
      st      <= ST_TRACK;
      trk_cnt <= '0;
      cur_ch  <= first_ch;
      sel_q   <= sel_c;
      multi_q <= is_multi(cfg_scan);
      skip_q  <= cfg_ref_pin;
      wr_idx  <= '0;
      rd_ptr  <= '0;
      sda_rel <= 1'b0;
    end else begin
      case (st)
        ST_TRACK: begin
          if (trk_cnt == TW'(TRK_CYC - 1)) st <= ST_CONV;
          else trk_cnt <= trk_cnt + TW'(1);
        end
        ST_CONV: begin
          if (conv_ready) begin
            if (step_last) begin
              st    <= ST_SERVE;
              n_res <= CNTW'(wr_idx) + CNTW'(1);
            end else begin
              st      <= ST_TRACK;
              trk_cnt <= '0;
              cur_ch  <= step_nxt;
              wr_idx  <= wr_idx + AW'(1);
            end
          end
        end
        ST_SERVE: begin
          if (pop_ok) rd_ptr <= ptr_last ? '0 : rd_ptr + AW'(1);
          if (bus_end) sda_rel <= 1'b0;
          else if (rd_nack) sda_rel <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  // per-channel stretch length, reset at each new channel
  always_ff @(posedge clk) begin
    if (!rst_n || addr_rd_evt || conv_done) str_cnt <= '0;
    else if (scl_hold && str_cnt != SW'(STRETCH_CYC)) str_cnt <= str_cnt + SW'(1);
  end

  assign scl_hold = tracking || (st == ST_CONV);
  assign conv_req = (st == ST_CONV);
  assign conv_ch  = cur_ch;
  assign rd_valid = (st == ST_SERVE);

  AST_REQ_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> scl_hold); // R3
  AST_TRACK_BEFORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(tracking) && $past(tracking, 2)); // R2
  AST_HOLD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_hold) |-> rd_valid && $past(conv_ready)); // R3
  AST_CH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> (conv_ch <= sel_q) && !(multi_q && skip_q && conv_ch == CW'(REF_CH))); // R7
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ok && ptr_last && !addr_rd_evt |=> rd_ptr == '0); // R8
  AST_NACK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    sda_rel && !addr_rd_evt |=> $stable(rd_ptr)); // R9
  AST_NO_RESCAN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !addr_rd_evt |=> !conv_req); // R10
  AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> str_cnt < SW'(STRETCH_CYC)); // R11
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
  localparam int NCH = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_rd_evt = 1'b0;
  logic [1:0] cfg_scan = 2'b00;
  logic [3:0] cfg_sel = 4'd0;
  logic cfg_ref_pin = 1'b0;
  logic conv_req, scl_hold, rd_valid, sda_rel;
  logic [3:0] conv_ch;
  logic conv_ready = 1'b0;
  logic [7:0] conv_data = 8'd0;
  logic [7:0] rd_byte;
  logic rd_ack = 1'b0, rd_nack = 1'b0, bus_end = 1'b0;

  int total = 0, bad = 0;
  int tot = 0, wait_cnt = 0;
  logic [3:0] log_ch [64];
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_scan_seq #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_rd_evt(addr_rd_evt),
    .cfg_scan(cfg_scan), .cfg_sel(cfg_sel), .cfg_ref_pin(cfg_ref_pin),
    .conv_req(conv_req), .conv_ch(conv_ch), .conv_ready(conv_ready),
    .conv_data(conv_data), .scl_hold(scl_hold), .rd_valid(rd_valid),
    .rd_byte(rd_byte), .rd_ack(rd_ack), .rd_nack(rd_nack),
    .bus_end(bus_end), .sda_rel(sda_rel)
  );

  function automatic logic [7:0] mdl(input int ch, input int idx);
    return 8'(((ch * 37) + (idx * 11)) ^ 8'h5A);
  endfunction

  // converter model with varying latency
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_ready = 1'b0;
      wait_cnt = 0;
    end else if (conv_ready) begin
      conv_ready = 1'b0;
    end else if (conv_req) begin
      if (wait_cnt == 0) begin
        conv_ready = 1'b1;
        conv_data = mdl(int'(conv_ch), tot);
        log_ch[tot % 64] = conv_ch;
        tot = tot + 1;
        wait_cnt = tot % 4;
      end else begin
        wait_cnt = wait_cnt - 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int expch [16];
    int n, base, s, cyc;
    bit multi;
    repeat (3) @(negedge clk);
    chk(!scl_hold && !conv_req && !rd_valid && !sda_rel, "R1",
        {scl_hold, conv_req, rd_valid, sda_rel}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sc = 0; sc < 4; sc++) begin
      for (int sl = 0; sl < 16; sl++) begin
        for (int rf = 0; rf < 2; rf++) begin
          multi = (sc == 0);
          s = (sl > NCH - 1) ? NCH - 1 : sl;
          n = 0;
          if (multi) begin
            for (int c = 0; c <= s; c++)
              if (!(rf == 1 && c == NCH - 1)) begin expch[n] = c; n++; end
          end else begin
            expch[0] = s;
            n = 1;
          end
          cfg_scan = 2'(sc);
          cfg_sel = 4'(sl);
          cfg_ref_pin = 1'(rf);
          base = tot;
          addr_rd_evt = 1'b1;
          @(negedge clk);
          addr_rd_evt = 1'b0;
          chk(scl_hold && !conv_req, "R2", {scl_hold, conv_req}, 2);
          @(negedge clk);
          chk(scl_hold && !conv_req, "R2", {scl_hold, conv_req}, 2);
          @(negedge clk);
          chk(conv_req === 1'b1, "R2", conv_req, 1);
          cyc = 0;
          while (scl_hold && cyc < 2000) begin
            @(negedge clk);
            cyc++;
          end
          chk(rd_valid && !scl_hold, "R3", {rd_valid, scl_hold}, 2);
          chk(tot - base == n, multi ? "R4" : "R5", tot - base, n);
          for (int k = 0; k < n; k++)
            chk(int'(log_ch[(base + k) % 64]) == expch[k],
                (sl > NCH - 1) ? "R6" : (rf == 1 ? "R7" : (multi ? "R4" : "R5")),
                int'(log_ch[(base + k) % 64]), expch[k]);
          if (sl == 5 || sl == 11) begin
            pulse(rd_nack);
            chk(sda_rel === 1'b1, "R9", sda_rel, 1);
            pulse(rd_ack);
            chk(rd_byte == mdl(expch[0], base), "R9", rd_byte, mdl(expch[0], base));
            pulse(bus_end);
            chk(sda_rel === 1'b0, "R9", sda_rel, 0);
          end
          for (int k = 0; k < n + 3; k++) begin
            chk(rd_byte == mdl(expch[k % n], base + (k % n)), "R8",
                rd_byte, mdl(expch[k % n], base + (k % n)));
            pulse(rd_ack);
          end
          repeat (10) @(negedge clk);
          chk((tot - base == n) && rd_valid && !conv_req, "R10", tot - base, n);
        end
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule